// File: doc/BRIEF.md
# Configuration Cycle Address Generator

This block sits in a host bridge and turns one software request for configuration space (bus number, device number, function number, byte offset and access size) into everything the bridge needs to run the cycle. A request on bus 0 becomes a type 0 cycle: the target device is picked by a single select line in the upper address bits. A request on any other bus becomes a type 1 cycle that carries the bus and device numbers so that a downstream bridge can forward it. From the same request the block forms the sparse-space CPU address, with the access size folded into its low bits, and it moves sub-dword data between the byte lanes of a 32-bit dword in both directions.

A request is a one-cycle strobe with all fields valid. One cycle later every output is registered and a done pulse marks them. The outputs then hold until the next strobe. A request that names a device which cannot be selected on bus 0, or that uses an illegal size or alignment, produces no cycle. Its error flag is raised and the read data comes back as all ones.

Top module: `cfg_addr_gen`

## Requirements
- R1: When bus is 0 and the request is legal, cyc_type is 0 and, among cycle address bits 31:11, exactly one bit is set: bit 11 plus the device number.
- R2: On bus 0 with a device number above 12, not_found is 1 and cyc_valid is 0. cyc_addr, sparse_addr and wdata_out are all zero and rdata_out is all ones.
- R3: In both cycle types, the cycle address carries the function number in bits 10:8, offset bits 7:2 (the dword register) in bits 7:2, and offset bits 1:0 in bits 1:0.
- R4: When bus is not 0 and the request is legal, cyc_type is 1. The cycle address carries the bus in bits 23:16 and the device in bits 15:11, and bits 31:24 are zero. Every device number, including those above 12, is accepted.
- R5: For a legal request, sparse_addr equals cyc_addr * 32 + (size - 1) * 8 + CFG_BASE, with the default CFG_BASE = 0x1E_0000_0000.
- R6: For a legal request, rdata_out equals rdata_in shifted right by 8 times offset[1:0], with zeros filling the top.
- R7: For a legal request, wdata_out equals wdata shifted left by 8 times offset[1:0], kept to 32 bits.
- R8: size_err is 1 unless size is 1, or size is 2 with offset[0] = 0, or size is 4 with offset[1:0] = 0. A request with size_err produces the same outputs as in R2 except for the flags themselves: cyc_valid 0, zero cyc_addr, sparse_addr and wdata_out, and all-ones rdata_out.
- R9: done is 1 exactly in the cycle after a cycle with req high. Outputs change only in that cycle and otherwise hold. After reset, done, cyc_valid, not_found and size_err are 0 and all address and data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, one cycle, fields valid with it |
| bus | input | 8 | Bus number |
| dev | input | 5 | Device number |
| func | input | 3 | Function number |
| offset | input | 8 | Byte offset in configuration space |
| size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| wdata | input | 32 | Write data, right-aligned |
| rdata_in | input | 32 | Dword returned by the configuration read |
| done | output | 1 | Pulse: registered results valid |
| cyc_valid | output | 1 | A cycle is to be issued for this request |
| cyc_type | output | 1 | 0 = type 0 cycle, 1 = type 1 cycle |
| cyc_addr | output | 32 | Configuration cycle address |
| sparse_addr | output | 40 | Sparse-space CPU address with the size encoded |
| wdata_out | output | 32 | Write data moved to its byte lanes |
| rdata_out | output | 32 | Read data right-aligned, or all ones on error |
| not_found | output | 1 | Device cannot be selected on bus 0 |
| size_err | output | 1 | Illegal size or misaligned access |

## Verification
The assertions assume that req is low while reset is held and that the request fields are stable in the cycle the strobe is sampled. The done and hold checks depend on that one edge. The bench drives each request as a single-cycle pulse set up on the falling edge and keeps req low through reset. It sweeps every device number on bus 0 and on several nonzero buses, together with every size from 0 to 4 and all four byte positions, so that both sides of the device limit and every legal and illegal alignment are reached.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  // Field positions that a configuration target decodes
  localparam int REG_LSB      = 2;
  localparam int FN_LSB       = 8;
  localparam int DEV_LSB      = 11;
  localparam int DEV_SEL_LSB  = 11;
  localparam int BUS_LSB      = 16;
  localparam int SPARSE_SHIFT = 5;
  localparam int SIZE_STEP    = 8;

  typedef enum logic {
    CYC_LOCAL  = 1'b0,
    CYC_BRIDGE = 1'b1
  } cyc_kind_e;
endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int DEV_W      = 5,
  parameter int FN_W       = 3,
  parameter int OFS_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int MAX_T0_DEV = 12
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FN_W-1:0]   func,
  input  logic [OFS_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr,
  output cyc_kind_e         kind,
  output logic              absent
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] common;
  logic [ADDR_W-1:0] local_sel;
  logic [ADDR_W-1:0] bridge_id;
  logic              on_root;

  assign on_root = (bus == '0);
  assign common  = (ADDR_W'(func) << FN_LSB) | ADDR_W'(offset);

  always_comb begin
    local_sel = '0;
    if (int'(dev) <= MAX_T0_DEV) begin
      local_sel = ONE << (DEV_SEL_LSB + int'(dev));
    end
  end

  assign bridge_id = (ADDR_W'(bus) << BUS_LSB) | (ADDR_W'(dev) << DEV_LSB);

  assign absent = on_root && (int'(dev) > MAX_T0_DEV);
  assign kind   = on_root ? CYC_LOCAL : CYC_BRIDGE;
  assign addr   = common | (on_root ? local_sel : bridge_id);
endmodule

// File: rtl/cfg_lane.sv
module cfg_lane #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [1:0]        ofs_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  output logic              bad,
  output logic [DATA_W-1:0] wdata_al,
  output logic [DATA_W-1:0] rdata_al
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [LANE_W-1:0] sh;
  logic              pow2;
  logic              fits;
  logic [SIZE_W-1:0] low_mask;

  assign sh       = ofs_lo[LANE_W-1:0];
  assign pow2     = (size != '0) && ((size & (size - 1'b1)) == '0);
  assign fits     = (int'(size) <= LANES);
  assign low_mask = size - 1'b1;
  assign bad      = !(pow2 && fits && ((SIZE_W'(sh) & low_mask) == '0));

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      wdata_al[8*j +: 8] = 8'h00;
      for (int k = 0; k <= j; k++) begin
        if (int'(sh) == k) wdata_al[8*j +: 8] = wdata[8*(j-k) +: 8];
      end
    end
    always_comb begin
      rdata_al[8*j +: 8] = 8'h00;
      for (int k = 0; k < LANES - j; k++) begin
        if (int'(sh) == k) rdata_al[8*j +: 8] = rdata[8*(j+k) +: 8];
      end
    end
  end
endmodule

// File: rtl/cfg_sparse.sv
module cfg_sparse
  import cfg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 3,
  parameter int SADDR_W  = 40,
  parameter logic [SADDR_W-1:0] CFG_BASE = 40'h1E_0000_0000
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SIZE_W-1:0]  size,
  output logic [SADDR_W-1:0] saddr
);
  logic [SADDR_W-1:0] size_code;

  assign size_code = SADDR_W'(size - 1'b1) * SADDR_W'(SIZE_STEP);
  assign saddr     = (SADDR_W'(addr) << SPARSE_SHIFT) + size_code + CFG_BASE;
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
  import cfg_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int DEV_W      = 5,
  parameter int FN_W       = 3,
  parameter int OFS_W      = 8,
  parameter int SIZE_W     = 3,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int SADDR_W    = 40,
  parameter int MAX_T0_DEV = 12,
  parameter logic [SADDR_W-1:0] CFG_BASE = 40'h1E_0000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEV_W-1:0]   dev,
  input  logic [FN_W-1:0]    func,
  input  logic [OFS_W-1:0]   offset,
  input  logic [SIZE_W-1:0]  size,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  rdata_in,
  output logic               done,
  output logic               cyc_valid,
  output logic               cyc_type,
  output logic [ADDR_W-1:0]  cyc_addr,
  output logic [SADDR_W-1:0] sparse_addr,
  output logic [DATA_W-1:0]  wdata_out,
  output logic [DATA_W-1:0]  rdata_out,
  output logic               not_found,
  output logic               size_err
);
  localparam int T1_TOP = BUS_LSB + BUS_W;

  logic [ADDR_W-1:0]  d_addr;
  cyc_kind_e          d_kind;
  logic               d_absent;
  logic               l_bad;
  logic [DATA_W-1:0]  l_wdata;
  logic [DATA_W-1:0]  l_rdata;
  logic [SADDR_W-1:0] s_addr;
  logic               issue;

  cfg_decode #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFS_W(OFS_W),
    .ADDR_W(ADDR_W), .MAX_T0_DEV(MAX_T0_DEV)
  ) decode_i (
    .bus(bus), .dev(dev), .func(func), .offset(offset),
    .addr(d_addr), .kind(d_kind), .absent(d_absent)
  );

  cfg_lane #(
    .DATA_W(DATA_W), .SIZE_W(SIZE_W)
  ) lane_i (
    .size(size), .ofs_lo(offset[1:0]), .wdata(wdata), .rdata(rdata_in),
    .bad(l_bad), .wdata_al(l_wdata), .rdata_al(l_rdata)
  );

  cfg_sparse #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SADDR_W(SADDR_W), .CFG_BASE(CFG_BASE)
  ) sparse_i (
    .addr(d_addr), .size(size), .saddr(s_addr)
  );

  assign issue = !d_absent && !l_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      cyc_valid   <= 1'b0;
      cyc_type    <= 1'b0;
      cyc_addr    <= '0;
      sparse_addr <= '0;
      wdata_out   <= '0;
      rdata_out   <= '0;
      not_found   <= 1'b0;
      size_err    <= 1'b0;
    end else begin
      done <= req;
      if (req) begin
        cyc_valid   <= issue;
        cyc_type    <= issue && (d_kind == CYC_BRIDGE);
        cyc_addr    <= issue ? d_addr : '0;
        sparse_addr <= issue ? s_addr : '0;
        wdata_out   <= issue ? l_wdata : '0;
        rdata_out   <= issue ? l_rdata : '1;
        not_found   <= d_absent;
        size_err    <= l_bad;
      end
    end
  end

  assert_t0_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && !cyc_type) |-> ($countones(cyc_addr[ADDR_W-1:DEV_SEL_LSB]) == 1));

  assert_absent_noissue_R2: assert property (@(posedge clk) disable iff (rst)
    not_found |-> (!cyc_valid && (cyc_addr == '0) && (rdata_out == '1)));

  assert_t1_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_type) |-> (cyc_addr[ADDR_W-1:T1_TOP] == '0));

  assert_misalign_noissue_R8: assert property (@(posedge clk) disable iff (rst)
    size_err |-> (!cyc_valid && (sparse_addr == '0) && (wdata_out == '0)));

  assert_done_follows_R9: assert property (@(posedge clk) disable iff (rst)
    req |=> done);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !req |=> !done);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !req |=> ($stable(cyc_addr) && $stable(rdata_out) && $stable(cyc_valid)));
endmodule

// File: tb/cfg_addr_gen_tb_top.sv
`timescale 1ns/1ps
module cfg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [7:0]  bus = '0;
  logic [4:0]  dev = '0;
  logic [2:0]  func = '0;
  logic [7:0]  offset = '0;
  logic [2:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_in = '0;
  logic        done, cyc_valid, cyc_type, not_found, size_err;
  logic [31:0] cyc_addr, wdata_out, rdata_out;
  logic [39:0] sparse_addr;

  int checks = 0;
  int errors = 0;
  localparam logic [39:0] BASE = 40'h1E_0000_0000;

  always #4 clk = ~clk;

  cfg_addr_gen dut_i (
    .clk(clk), .rst(rst), .req(req), .bus(bus), .dev(dev), .func(func),
    .offset(offset), .size(size), .wdata(wdata), .rdata_in(rdata_in),
    .done(done), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .cyc_addr(cyc_addr), .sparse_addr(sparse_addr), .wdata_out(wdata_out),
    .rdata_out(rdata_out), .not_found(not_found), .size_err(size_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                         input logic [7:0] o, input logic [2:0] s,
                         input logic [31:0] w, input logic [31:0] r);
    logic        e_nf, e_se, e_ok, e_t1;
    logic [31:0] e_addr, e_wd, e_rd;
    logic [39:0] e_sp;
    int          shb;
    bus = b; dev = d; func = f; offset = o; size = s; wdata = w; rdata_in = r;
    req = 1'b1;
    e_t1 = (b != 0);
    e_nf = (b == 0) && (d > 12);
    e_se = !((s == 1) || (s == 2 && o[0] == 1'b0) || (s == 4 && o[1:0] == 2'b00));
    e_ok = !e_nf && !e_se;
    shb  = 8 * int'(o[1:0]);
    if (e_t1) e_addr = (32'(b) << 16) | (32'(d) << 11) | (32'(f) << 8) | 32'(o);
    else      e_addr = (32'd1 << (11 + int'(d))) | (32'(f) << 8) | 32'(o);
    e_sp = 40'(e_addr) * 40'd32 + 40'((int'(s) - 1) * 8) + BASE;
    e_wd = 32'(64'(w) << shb);
    e_rd = r >> shb;
    if (!e_ok) begin
      e_addr = '0; e_sp = '0; e_wd = '0; e_rd = 32'hFFFF_FFFF; e_t1 = 1'b0;
    end
    @(negedge clk);
    req = 1'b0;
    chk("R9 done", 64'(done), 64'd1);
    chk("R2 not_found", 64'(not_found), 64'(e_nf));
    chk("R8 size_err", 64'(size_err), 64'(e_se));
    chk(e_ok ? "R1/R4 cyc_valid" : "R2/R8 cyc_valid", 64'(cyc_valid), 64'(e_ok));
    chk(b != 0 ? "R4 cyc_type" : "R1 cyc_type", 64'(cyc_type), 64'(e_t1));
    chk(b != 0 ? "R4/R3 cyc_addr" : "R1/R3 cyc_addr", 64'(cyc_addr), 64'(e_addr));
    chk("R5 sparse_addr", 64'(sparse_addr), 64'(e_sp));
    chk("R7 wdata_out", 64'(wdata_out), 64'(e_wd));
    chk("R6 rdata_out", 64'(rdata_out), 64'(e_rd));
    @(negedge clk);
    chk("R9 done falls", 64'(done), 64'd0);
    chk("R9 cyc_addr holds", 64'(cyc_addr), 64'(e_addr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] buses [4];
    logic [31:0] w;
    logic [31:0] r;
    int n;
    buses[0] = 8'h00; buses[1] = 8'h01; buses[2] = 8'h80; buses[3] = 8'hFF;
    n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset done", 64'(done), 64'd0);
    chk("R9 reset cyc_valid", 64'(cyc_valid), 64'd0);
    chk("R9 reset flags", 64'({not_found, size_err}), 64'd0);
    chk("R9 reset cyc_addr", 64'(cyc_addr), 64'd0);
    chk("R9 reset sparse", 64'(sparse_addr), 64'd0);
    chk("R9 reset data", 64'({wdata_out, rdata_out}), 64'd0);
    for (int bi = 0; bi < 4; bi++) begin
      for (int d = 0; d < 32; d++) begin
        for (int s = 0; s < 5; s++) begin
          for (int oi = 0; oi < 4; oi++) begin
            logic [7:0] o;
            o = 8'(((d * 7 + oi * 13 + s) & 63) << 2) | 8'(oi);
            w = 32'h1234_5678 ^ (32'(n) * 32'h9E37_79B9);
            r = 32'hCAFE_F00D ^ (32'(n) * 32'h0101_0F1F);
            run_one(buses[bi], 5'(d), 3'((d + oi) % 8), o, 3'(s), w, r);
            n++;
          end
        end
      end
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule